// File: doc/BRIEF.md
# Result Queue with Drain and Overflow Flags

This block buffers conversion results that a producer hands over one at a time, and lets a bus master drain them in arrival order through a pop read. The queue holds four 16-bit results. A drain flag tells the consumer that results are waiting. Depending on a select bit, that flag raises either an interrupt line or a DMA request line. An enable gates both lines.

When a result arrives while all four slots are occupied and nothing is popped in that cycle, the new result is thrown away and the stored results are left as they were. A sticky overflow flag records the loss and drives its own gated interrupt. Software clears the flags with a write strobe. Bit 0 of the write data clears the drain flag, and bit 1 clears the overflow flag.

The drain flag is kept by a three-state machine:
- `DRN_EMPTY`: the queue is empty and the flag is 0. The machine moves to `DRN_PENDING` when a result is accepted.
- `DRN_PENDING`: the flag is 1. The machine moves to `DRN_EMPTY` when the queue drains. It moves to `DRN_ACKED` when software clears the flag in interrupt mode, provided the queue stays non-empty and no result is accepted in that cycle.
- `DRN_ACKED`: the flag is 0 while results remain. The machine returns to `DRN_PENDING` on the next accepted result, or goes to `DRN_EMPTY` when the queue drains.

The overflow flag is kept by a two-state machine. It moves from `OVF_CLEAR` to `OVF_SET` on a dropped result. It moves back from `OVF_SET` to `OVF_CLEAR` on a software clear, unless a new drop happens in the same cycle.

Top module: `result_queue`

## Requirements
- R1: After reset the queue is empty, both flags are 0, all request lines are 0 and `pop_data` is 0.
- R2: Results are returned through `pop_data` in the order they were accepted. `pop_data` shows the oldest entry during the cycle in which `pop_rd` is high, and the pop takes effect at the next clock edge.
- R3: A pop of an empty queue shows 0 on `pop_data` and changes no state.
- R4: A result that arrives while the queue holds 4 entries, with no pop in the same cycle, is discarded without changing any stored entry. `ovf_flag` reads 1 from the next cycle.
- R5: When a result arrives and a pop happens in the same cycle on a full queue, the result is accepted and `ovf_flag` is not set.
- R6: `drain_flag` reads 1 in the cycle after a result is accepted. It reads 0 in the cycle after the queue becomes empty, in either mode.
- R7: `drain_irq` equals `drain_flag & drain_en & ~drain_sel`, and `drain_dma` equals `drain_flag & drain_en & drain_sel`.
- R8: In interrupt mode (`drain_sel`=0), a write with `flag_wdata[0]`=1 clears `drain_flag` until the next accepted result. A write with `flag_wdata[0]`=0 leaves the flag unchanged.
- R9: In DMA mode (`drain_sel`=1), a write with `flag_wdata[0]`=1 has no effect on `drain_flag`.
- R10: `ovf_flag` stays set until a write with `flag_wdata[1]`=1 clears it. A write with that bit 0 leaves it set.
- R11: `ovf_irq` equals `ovf_flag & ovf_en`.
- R12: A clear of the overflow flag in the same cycle as a new dropped result leaves `ovf_flag` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Producer offers a result this cycle |
| res_data | input | 16 | Result value |
| pop_rd | input | 1 | Bus read of the pop register |
| pop_data | output | 16 | Oldest stored result, or 0 when the queue is empty |
| flag_wr | input | 1 | Flag-clear write strobe |
| flag_wdata | input | 2 | Bit 0 clears the drain flag, bit 1 clears the overflow flag |
| drain_en | input | 1 | Drain request enable |
| drain_sel | input | 1 | 0 selects an interrupt, 1 selects a DMA request |
| ovf_en | input | 1 | Overflow interrupt enable |
| drain_flag | output | 1 | Results are waiting |
| ovf_flag | output | 1 | Sticky overflow flag |
| drain_irq | output | 1 | Drain interrupt request |
| drain_dma | output | 1 | Drain DMA request |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The queue is exercised with four input patterns:
- Single pushes and pops show arrival order and the timing of the drain flag.
- Pops of an empty queue show that nothing changes and that 0 is returned.
- Filling the queue and then pushing again distinguishes a dropped result from an overwrite, because the scoreboard later expects only the older values.
- A push together with a pop on a full queue separates acceptance from overflow.

Flag-clear writes are sent in both modes, with the clear bit set and with it cleared, and one clear is timed to coincide with a new drop. Together these show write-one-to-clear, the DMA-mode lockout and clear-versus-set priority.

// File: rtl/rfq_pkg.sv
package rfq_pkg;
    typedef enum logic [1:0] {
        DRN_EMPTY   = 2'd0,
        DRN_PENDING = 2'd1,
        DRN_ACKED   = 2'd2
    } drain_state_t;

    typedef enum logic {
        OVF_CLEAR = 1'b0,
        OVF_SET   = 1'b1
    } ovf_state_t;
endpackage

// File: rtl/rfq_store.sv
module rfq_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  level,
    output logic              empty,
    output logic              full
);
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slot_q[i] <= '0;
                else if (push && wr_ptr == PTR_W'(i))
                    slot_q[i] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            level <= level + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign empty = (level == '0);
    assign full  = (level == CNT_W'(DEPTH));
    assign head  = empty ? '0 : slot_q[rd_ptr];

    // R5: push together with pop keeps the occupancy
    a_r5_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(level));
    // R4: no write into a full store unless a slot is freed in the same cycle
    a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |-> !push);
endmodule

// File: rtl/rfq_drain_ctl.sv
module rfq_drain_ctl
    import rfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_ok,
    input  logic next_empty,
    input  logic clr_req,
    input  logic sel,
    input  logic en,
    output logic flag,
    output logic irq,
    output logic dma
);
    drain_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= DRN_EMPTY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRN_EMPTY: begin
                if (!next_empty)
                    state_d = DRN_PENDING;
            end
            DRN_PENDING: begin
                if (next_empty)
                    state_d = DRN_EMPTY;
                else if (clr_req && !sel && !push_ok)
                    state_d = DRN_ACKED;
            end
            DRN_ACKED: begin
                if (next_empty)
                    state_d = DRN_EMPTY;
                else if (push_ok)
                    state_d = DRN_PENDING;
            end
            default: state_d = DRN_EMPTY;
        endcase
    end

    always_comb begin
        flag = (state_q == DRN_PENDING);
        irq  = flag && en && !sel;
        dma  = flag && en && sel;
    end

    // R9: a software clear in DMA mode never drops the flag
    a_r9_dma_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && sel && !next_empty) |=> flag);
    // R6: an accepted result raises the flag on the next cycle
    a_r6_push_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> flag);
    // R7: interrupt and DMA requests are exclusive
    a_r7_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma));
endmodule

// File: rtl/rfq_ovf_ctl.sv
module rfq_ovf_ctl
    import rfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr_req,
    input  logic en,
    output logic flag,
    output logic irq
);
    ovf_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= OVF_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR: if (drop) state_d = OVF_SET;
            OVF_SET:   if (clr_req && !drop) state_d = OVF_CLEAR;
            default:   state_d = OVF_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == OVF_SET);
        irq  = flag && en;
    end

    // R12: a drop always leaves the flag set, even with a concurrent clear
    a_r12_drop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> flag);
    // R10: without a clear the flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/result_queue.sv
module result_queue #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              pop_rd,
    output logic [DATA_W-1:0] pop_data,
    input  logic              flag_wr,
    input  logic [1:0]        flag_wdata,
    input  logic              drain_en,
    input  logic              drain_sel,
    input  logic              ovf_en,
    output logic              drain_flag,
    output logic              ovf_flag,
    output logic              drain_irq,
    output logic              drain_dma,
    output logic              ovf_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] level, next_level;
    logic             empty, full, pop_ok, push_ok, drop;

    assign pop_ok     = pop_rd && !empty;
    assign push_ok    = res_valid && (!full || pop_ok);
    assign drop       = res_valid && full && !pop_ok;
    assign next_level = level + CNT_W'(push_ok) - CNT_W'(pop_ok);

    rfq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .wdata (res_data),
        .pop   (pop_ok),
        .head  (pop_data),
        .level (level),
        .empty (empty),
        .full  (full)
    );

    rfq_drain_ctl u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_ok    (push_ok),
        .next_empty (next_level == '0),
        .clr_req    (flag_wr && flag_wdata[0]),
        .sel        (drain_sel),
        .en         (drain_en),
        .flag       (drain_flag),
        .irq        (drain_irq),
        .dma        (drain_dma)
    );

    rfq_ovf_ctl u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .drop    (drop),
        .clr_req (flag_wr && flag_wdata[1]),
        .en      (ovf_en),
        .flag    (ovf_flag),
        .irq     (ovf_irq)
    );

    // R3: popping an empty queue changes nothing
    a_r3_empty_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_rd && empty && !res_valid) |=> ($stable(level) && $stable(drain_flag)));
    // R6: an empty queue never shows the drain flag
    a_r6_empty_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !drain_flag);
    // R4: a full queue with a new result and no pop records an overflow
    a_r4_overflow_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && full && !pop_rd) |=> (ovf_flag && full));
endmodule

// File: tb/result_queue_test.sv
module result_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        pop_rd = 1'b0;
    logic [15:0] pop_data;
    logic        flag_wr = 1'b0;
    logic [1:0]  flag_wdata = '0;
    logic        drain_en = 1'b0, drain_sel = 1'b0, ovf_en = 1'b0;
    logic        drain_flag, ovf_flag, drain_irq, drain_dma, ovf_irq;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    result_queue uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .pop_rd(pop_rd), .pop_data(pop_data), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .drain_en(drain_en), .drain_sel(drain_sel),
        .ovf_en(ovf_en), .drain_flag(drain_flag), .ovf_flag(ovf_flag),
        .drain_irq(drain_irq), .drain_dma(drain_dma), .ovf_irq(ovf_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and records accepted results
    task automatic step(input logic pv, input logic [15:0] d, input logic pr,
                        input logic wr, input logic [1:0] wd);
        bit will_pop;
        will_pop = pr && (exp_q.size() > 0);
        res_valid = pv; res_data = d; pop_rd = pr; flag_wr = wr; flag_wdata = wd;
        if (pv && (exp_q.size() < 4 || will_pop))
            exp_q.push_back(d);
        @(posedge clk); #1;
        res_valid = 1'b0; pop_rd = 1'b0; flag_wr = 1'b0; flag_wdata = '0;
    endtask

    // monitor: compares each popped value against the scoreboard (R2, R3)
    always @(negedge clk) begin
        if (rst_n && pop_rd) begin
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(pop_data == e, "R2 pop order", pop_data, e);
            end else begin
                chk(pop_data == 16'h0, "R3 empty pop data", pop_data, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(drain_flag == 0 && ovf_flag == 0, "R1 flags", {drain_flag, ovf_flag}, 0);
        chk(drain_irq == 0 && drain_dma == 0 && ovf_irq == 0, "R1 requests",
            {drain_irq, drain_dma, ovf_irq}, 0);
        chk(pop_data == 0, "R1 pop_data", pop_data, 0);

        drain_en = 1'b1; drain_sel = 1'b0;
        step(1, 16'hA001, 0, 0, 2'b00);
        chk(drain_flag == 1, "R6 set after push", drain_flag, 1);
        chk(drain_irq == 1 && drain_dma == 0, "R7 irq mode", {drain_irq, drain_dma}, 2'b10);
        drain_en = 1'b0; #1;
        chk(drain_irq == 0, "R7 enable gates", drain_irq, 0);
        drain_en = 1'b1;

        step(0, 0, 0, 1, 2'b10);
        chk(drain_flag == 1, "R8 write0 no effect", drain_flag, 1);
        step(0, 0, 0, 1, 2'b01);
        chk(drain_flag == 0, "R8 w1c clears", drain_flag, 0);
        chk(drain_irq == 0, "R8 irq drops", drain_irq, 0);
        step(1, 16'hA002, 0, 0, 2'b00);
        chk(drain_flag == 1, "R8 new push re-raises", drain_flag, 1);

        step(0, 0, 1, 0, 2'b00);
        chk(drain_flag == 1, "R6 still holding", drain_flag, 1);
        step(0, 0, 1, 0, 2'b00);
        chk(drain_flag == 0, "R6 clears on empty", drain_flag, 0);

        step(0, 0, 1, 0, 2'b00);
        chk(drain_flag == 0 && ovf_flag == 0, "R3 no state change",
            {drain_flag, ovf_flag}, 0);

        for (int i = 0; i < 4; i++) step(1, 16'hB000 + 16'(i), 0, 0, 2'b00);
        chk(ovf_flag == 0, "R4 no overflow at fill", ovf_flag, 0);
        step(1, 16'hBEEF, 0, 0, 2'b00);
        chk(ovf_flag == 1, "R4 overflow flagged", ovf_flag, 1);
        ovf_en = 1'b1; #1;
        chk(ovf_irq == 1, "R11 ovf irq", ovf_irq, 1);
        ovf_en = 1'b0; #1;
        chk(ovf_irq == 0, "R11 ovf irq gated", ovf_irq, 0);

        step(0, 0, 0, 1, 2'b01);
        chk(ovf_flag == 1, "R10 write0 keeps", ovf_flag, 1);
        step(1, 16'hBAD0, 0, 1, 2'b10);
        chk(ovf_flag == 1, "R12 drop beats clear", ovf_flag, 1);
        step(0, 0, 0, 1, 2'b10);
        chk(ovf_flag == 0, "R10 w1c clears", ovf_flag, 0);

        step(1, 16'hC005, 1, 0, 2'b00);
        chk(ovf_flag == 0, "R5 push+pop on full", ovf_flag, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 2'b00);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        chk(drain_flag == 0, "R6 empty after drain", drain_flag, 0);

        drain_sel = 1'b1;
        step(1, 16'hD001, 0, 0, 2'b00);
        chk(drain_dma == 1 && drain_irq == 0, "R7 dma mode", {drain_irq, drain_dma}, 2'b01);
        step(0, 0, 0, 1, 2'b01);
        chk(drain_flag == 1, "R9 dma ignores w1c", drain_flag, 1);
        step(0, 0, 1, 0, 2'b00);
        chk(drain_flag == 0 && drain_dma == 0, "R9 hw clear on empty",
            {drain_flag, drain_dma}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule